// File: doc/BRIEF.md
# Vector Byte-Window Double Shifter

This block is a 128-bit vector execution slice. It takes two 16-byte source vectors and a 4-bit byte offset. It returns the 16-byte window that begins at that offset inside the 32-byte string made of source A followed by source B. Byte lanes are numbered big-endian: lane 0 is the most significant byte (bits 127:120). An offset of zero gives source A unchanged. Larger offsets pull bytes from the top of source B into the low lanes.

The block also decodes the instruction word. Two encodings carry the operation. The narrow form names three registers with 5-bit indices. The wide form builds 7-bit indices out of scattered bit fields, for a 128-entry register file. The decode results come out combinationally. They give the destination, both source indices, the shift amount, the form and a valid flag. The window result and the destination index are captured on an issue strobe and appear one cycle later. Register storage stays outside the block.

Top module: `vbw_unit`

## Requirements
- R1: With offset SH, output byte lane i equals byte i+SH of the 32-byte string {src_a, src_b}, where byte 0 of that string is src_a[127:120] and byte 16 is src_b[127:120].
- R2: With SH = 0 the captured result equals src_a exactly.
- R3: Narrow form is recognised when instr[31:26] = 4 and instr[5:0] = 44. Its destination is instr[25:21], source A is instr[20:16] and source B is instr[15:11], each zero-extended to 7 bits. The shift is instr[9:6], and instr[10] has no effect on it.
- R4: Wide form is recognised when instr[31:26] = 4 and instr[4] = 1. Its destination is {instr[3:2], instr[25:21]}, source A is {instr[10], instr[5], instr[20:16]}, source B is {instr[1:0], instr[15:11]} and the shift is instr[9:6].
- R5: dec_valid is low for any word that matches neither form. dec_wide is 1 for the wide form and 0 for the narrow form.
- R6: When in_valid and dec_valid are both high at a clock edge, out_valid is high after that edge. At the same time out_data carries the window and out_dst carries the decoded destination.
- R7: If in_valid is low, or the word does not decode, out_valid is low after the edge and out_data and out_dst keep their previous values.
- R8: Synchronous reset drives out_valid, out_data and out_dst to zero.
- R9: With SH = 15, lane 0 of the result is src_a[7:0] and lanes 1 to 15 are src_b bytes 0 to 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue strobe for the current instruction |
| instr | input | 32 | Instruction word |
| src_a | input | 128 | Source vector A (lane 0 in bits 127:120) |
| src_b | input | 128 | Source vector B |
| dec_valid | output | 1 | Word matches one of the two forms |
| dec_wide | output | 1 | 1 = wide form, 0 = narrow form |
| dec_dst | output | 7 | Decoded destination index |
| dec_src_a | output | 7 | Decoded source A index |
| dec_src_b | output | 7 | Decoded source B index |
| dec_shift | output | 4 | Decoded byte offset |
| out_valid | output | 1 | Registered result valid |
| out_data | output | 128 | Registered window result |
| out_dst | output | 7 | Registered destination index |

## Verification
Every offset from 0 to 15 is run in both encodings. Each run uses four vector patterns, and each pattern tells different faults apart:
- Ascending byte labels in A and B show exactly which source byte reached each lane, so off-by-one and reversed-lane faults stand out.
- All-ones A against all-zero B shows where the A/B boundary falls.
- Random vectors catch bit-level crosstalk inside lanes.
- A zero A against a patterned B shows that no byte of A leaks past its share.

Register indices are swept so that every high bit of the wide form is set in some case. Malformed words, idle cycles and a reset in mid-run check that the result holds or clears.

// File: rtl/vbw_pkg.sv
package vbw_pkg;

    localparam int INSTR_W     = 32;
    localparam int IDX_W       = 7;
    localparam int NARROW_W    = 5;
    localparam int SH_FIELD_W  = 4;

    localparam logic [5:0] PRIMARY_OP = 6'd4;
    localparam logic [5:0] NARROW_XO  = 6'd44;

    typedef enum logic {
        FORM_NARROW = 1'b0,
        FORM_WIDE   = 1'b1
    } form_e;

    typedef struct packed {
        logic                  valid;
        form_e                 form;
        logic [IDX_W-1:0]      dst;
        logic [IDX_W-1:0]      src_a;
        logic [IDX_W-1:0]      src_b;
        logic [SH_FIELD_W-1:0] shift;
    } dec_t;

endpackage

// File: rtl/vbw_decode.sv
module vbw_decode
    import vbw_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);

    logic                is_op4;
    logic                hit_narrow;
    logic                hit_wide;
    logic [NARROW_W-1:0] f_dst;
    logic [NARROW_W-1:0] f_a;
    logic [NARROW_W-1:0] f_b;

    // Field positions use LSB-0 numbering (MSB-0 bit n is instr[31-n]).
    always_comb begin
        is_op4     = (instr[31:26] == PRIMARY_OP);
        hit_wide   = is_op4 && instr[4];
        hit_narrow = is_op4 && !instr[4] && (instr[5:0] == NARROW_XO);
        f_dst      = instr[25:21];
        f_a        = instr[20:16];
        f_b        = instr[15:11];
    end

    always_comb begin
        dec       = '0;
        dec.shift = instr[9:6];
        if (hit_wide) begin
            dec.valid = 1'b1;
            dec.form  = FORM_WIDE;
            dec.dst   = {instr[3:2], f_dst};
            dec.src_a = {instr[10], instr[5], f_a};
            dec.src_b = {instr[1:0], f_b};
        end else if (hit_narrow) begin
            dec.valid = 1'b1;
            dec.form  = FORM_NARROW;
            dec.dst   = {2'b00, f_dst};
            dec.src_a = {2'b00, f_a};
            dec.src_b = {2'b00, f_b};
        end else begin
            dec.valid = 1'b0;
            dec.form  = FORM_NARROW;
        end
    end

endmodule

// File: rtl/vbw_funnel.sv
module vbw_funnel #(
    parameter int DATA_W = 128,
    localparam int LANES = DATA_W / 8,
    localparam int SH_W  = $clog2(LANES),
    localparam int CAT_B = 2 * LANES
) (
    input  logic [DATA_W-1:0] hi,
    input  logic [DATA_W-1:0] lo,
    input  logic [SH_W-1:0]   sh,
    output logic [DATA_W-1:0] win
);

    logic [2*DATA_W-1:0] cat;
    logic [7:0]          cat_b [CAT_B];

    assign cat = {hi, lo};

    // Byte k of the concatenation, k = 0 is the most significant byte.
    for (genvar k = 0; k < CAT_B; k++) begin : g_split
        assign cat_b[k] = cat[2*DATA_W-1-8*k -: 8];
    end

    // One selector per output lane: lane i takes concatenation byte i+sh.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SH_W:0] pick;
        always_comb begin
            pick = (SH_W+1)'(i) + {1'b0, sh};
            win[DATA_W-1-8*i -: 8] = cat_b[pick];
        end
    end

endmodule

// File: rtl/vbw_unit.sv
module vbw_unit
    import vbw_pkg::*;
#(
    parameter int DATA_W = 128,
    localparam int LANES = DATA_W / 8,
    localparam int SH_W  = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [31:0]        instr,
    input  logic [DATA_W-1:0]  src_a,
    input  logic [DATA_W-1:0]  src_b,
    output logic               dec_valid,
    output logic               dec_wide,
    output logic [6:0]         dec_dst,
    output logic [6:0]         dec_src_a,
    output logic [6:0]         dec_src_b,
    output logic [3:0]         dec_shift,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic [6:0]         out_dst
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [IDX_W-1:0]  dst;
    } stage_t;

    dec_t              dec;
    logic [DATA_W-1:0] window;
    logic              take;
    stage_t            stage_d;
    stage_t            stage_q;

    vbw_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    vbw_funnel #(.DATA_W(DATA_W)) u_funnel (
        .hi  (src_a),
        .lo  (src_b),
        .sh  (dec.shift[SH_W-1:0]),
        .win (window)
    );

    assign dec_valid = dec.valid;
    assign dec_wide  = (dec.form == FORM_WIDE);
    assign dec_dst   = dec.dst;
    assign dec_src_a = dec.src_a;
    assign dec_src_b = dec.src_b;
    assign dec_shift = dec.shift;

    always_comb begin
        take          = in_valid && dec.valid;
        stage_d       = stage_q;
        stage_d.valid = take;
        if (take) begin
            stage_d.data = window;
            stage_d.dst  = dec.dst;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

    assign out_valid = stage_q.valid;
    assign out_data  = stage_q.data;
    assign out_dst   = stage_q.dst;

    AST_ISSUE_RESULT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec_valid) |=> out_valid); // R6

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && dec_valid) |=> !out_valid); // R7

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && dec_valid) |=> ($stable(out_data) && $stable(out_dst))); // R7

    AST_ZERO_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec_valid && dec_shift == 4'd0) |=> (out_data == $past(src_a))); // R2

    AST_TOP_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec_valid && dec_shift == 4'd15)
        |=> (out_data[DATA_W-1 -: 8] == $past(src_a[7:0]))); // R9

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0 && out_dst == '0)); // R8

endmodule

// File: tb/vbw_unit_tb.sv
module vbw_unit_tb;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [31:0]  instr;
    logic [127:0] src_a;
    logic [127:0] src_b;
    logic         dec_valid;
    logic         dec_wide;
    logic [6:0]   dec_dst;
    logic [6:0]   dec_src_a;
    logic [6:0]   dec_src_b;
    logic [3:0]   dec_shift;
    logic         out_valid;
    logic [127:0] out_data;
    logic [6:0]   out_dst;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;

    vbw_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b),
        .dec_valid(dec_valid), .dec_wide(dec_wide), .dec_dst(dec_dst),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_shift(dec_shift),
        .out_valid(out_valid), .out_data(out_data), .out_dst(out_dst)
    );

    function automatic logic [127:0] ref_window(logic [127:0] a, logic [127:0] b, int sh);
        logic [255:0] c;
        c = {a, b} << (8 * sh);
        return c[255:128];
    endfunction

    function automatic logic [31:0] enc_narrow(logic [4:0] d, logic [4:0] a, logic [4:0] b,
                                               logic [3:0] sh, logic spare);
        return {6'd4, d, a, b, spare, sh, 6'd44};
    endfunction

    function automatic logic [31:0] enc_wide(logic [6:0] d, logic [6:0] a, logic [6:0] b,
                                             logic [3:0] sh);
        return {6'd4, d[4:0], a[4:0], b[4:0], a[6], sh, a[5], 1'b1, d[6:5], b[6:5]};
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic make_vectors(int pat, output logic [127:0] a, output logic [127:0] b);
        for (int i = 0; i < 16; i++) begin
            case (pat)
                0: begin a[127-8*i -: 8] = 8'(i);        b[127-8*i -: 8] = 8'(8'h10 + i); end
                1: begin a[127-8*i -: 8] = 8'($urandom); b[127-8*i -: 8] = 8'($urandom); end
                2: begin a[127-8*i -: 8] = 8'hFF;        b[127-8*i -: 8] = 8'h00;        end
                default: begin a[127-8*i -: 8] = 8'h00;  b[127-8*i -: 8] = 8'(8'hA5 ^ i); end
            endcase
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] a, b, keep_data;
        logic [6:0]   d7, a7, b7, keep_dst;
        logic [31:0]  bad [4];

        rst = 1'b1; in_valid = 1'b0; instr = '0; src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        check("R8 reset out_valid", 128'(out_valid), 128'd0);
        check("R8 reset out_data", out_data, 128'd0);
        check("R8 reset out_dst", 128'(out_dst), 128'd0);
        rst = 1'b0;

        // Full sweep: both forms, four patterns, every offset.
        for (int form = 0; form < 2; form++) begin
            for (int pat = 0; pat < 4; pat++) begin
                for (int sh = 0; sh < 16; sh++) begin
                    make_vectors(pat, a, b);
                    d7 = 7'((sh * 9 + pat * 37 + 3) % 128);
                    a7 = 7'((sh * 13 + pat * 31 + 64) % 128);
                    b7 = 7'((sh * 7 + pat * 41 + 96) % 128);
                    if (form == 0) begin
                        d7[6:5] = 2'b00; a7[6:5] = 2'b00; b7[6:5] = 2'b00;
                        instr = enc_narrow(d7[4:0], a7[4:0], b7[4:0], 4'(sh), pat[0]);
                    end else begin
                        instr = enc_wide(d7, a7, b7, 4'(sh));
                    end
                    src_a = a; src_b = b; in_valid = 1'b1;
                    #1;
                    if (form == 0) begin
                        check("R3 narrow valid", 128'(dec_valid), 128'd1);
                        check("R5 narrow form flag", 128'(dec_wide), 128'd0);
                        check("R3 narrow dst", 128'(dec_dst), 128'(d7));
                        check("R3 narrow src_a", 128'(dec_src_a), 128'(a7));
                        check("R3 narrow src_b", 128'(dec_src_b), 128'(b7));
                        check("R3 narrow shift", 128'(dec_shift), 128'(sh));
                    end else begin
                        check("R4 wide valid", 128'(dec_valid), 128'd1);
                        check("R5 wide form flag", 128'(dec_wide), 128'd1);
                        check("R4 wide dst", 128'(dec_dst), 128'(d7));
                        check("R4 wide src_a", 128'(dec_src_a), 128'(a7));
                        check("R4 wide src_b", 128'(dec_src_b), 128'(b7));
                        check("R4 wide shift", 128'(dec_shift), 128'(sh));
                    end
                    @(negedge clk);
                    check("R6 out_valid after issue", 128'(out_valid), 128'd1);
                    check("R6 out_dst", 128'(out_dst), 128'(d7));
                    check("R1 window", out_data, ref_window(a, b, sh));
                    if (sh == 0)  check("R2 zero offset", out_data, a);
                    if (sh == 15) check("R9 top offset", out_data, {a[7:0], b[127:8]});
                end
            end
        end

        // Non-matching words: no decode, no capture, result held.
        bad[0] = {6'd5, 20'h12345, 6'd44};
        bad[1] = {6'd4, 20'h0F0F0, 6'd45};
        bad[2] = {6'd4, 20'hABCDE, 6'd0};
        bad[3] = {6'd3, 20'h00000, 6'b011100};
        keep_data = out_data; keep_dst = out_dst;
        for (int k = 0; k < 4; k++) begin
            instr = bad[k]; src_a = ~src_a; src_b = ~src_b; in_valid = 1'b1;
            #1;
            check("R5 non-matching word", 128'(dec_valid), 128'd0);
            @(negedge clk);
            check("R7 no capture on bad word", 128'(out_valid), 128'd0);
            check("R7 data held", out_data, keep_data);
            check("R7 dst held", 128'(out_dst), 128'(keep_dst));
        end

        // Idle strobe with a valid word.
        instr = enc_wide(7'h7F, 7'h41, 7'h22, 4'd5); in_valid = 1'b0;
        src_a = 128'h1; src_b = 128'h2;
        @(negedge clk);
        check("R7 idle no valid", 128'(out_valid), 128'd0);
        check("R7 idle data held", out_data, keep_data);

        // Capture then reset in mid-run.
        in_valid = 1'b1;
        @(negedge clk);
        check("R6 capture before reset", 128'(out_dst), 128'h7F);
        rst = 1'b1;
        @(negedge clk);
        check("R8 mid-run reset valid", 128'(out_valid), 128'd0);
        check("R8 mid-run reset data", out_data, 128'd0);
        check("R8 mid-run reset dst", 128'(out_dst), 128'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule